// File: doc/BRIEF.md
# Oscillator Frequency Word Programming Port

This block is the host-facing programming port of a numerically controlled oscillator. A host on an 8-bit bus builds a 48-bit phase increment one byte at a time in a staging buffer. Each byte is picked by a 3-bit address and captured on the rising edge of an active-low write strobe. The write strobe is not related to the oscillator clock. While bytes are being staged, the phase increment that the accumulator uses stays unchanged.

A separate active-low load strobe commits the staged word. The load strobe is brought into the clock domain by a two-flop synchronizer, and its falling edge produces a single-cycle commit pulse. That pulse copies the staged word into the active frequency register.

The commit pulse also enters a delay line as long as the oscillator's pipeline. The line's output is the sync pulse, which marks the cycle in which the new frequency reaches the oscillator output. An asynchronous active-low reset clears everything, including the staging buffer.

Top module: `nco_freq_loader`

## Requirements
- R1: On a rising edge of `wr_n` with `cs_n` low, `din` is stored in staged byte `addr`, which occupies bits 8*addr+7 down to 8*addr of the staged word. Address 0 is the least significant byte and address 5 the most significant byte. After the next commit, `freq_word` equals the staged word.
- R2: A rising edge of `wr_n` while `cs_n` is high changes no staged byte.
- R3: A write to address 6 or 7 changes no staged byte.
- R4: `freq_word` changes only on the clock edge that directly follows a cycle in which `commit` is high. Staging writes alone leave it unchanged.
- R5: A falling edge of `load_n` that arrives between clock edges N and N+1 makes `commit` high for exactly one cycle, the cycle after edge N+2. A rising edge of `load_n` produces no commit.
- R6: `sync` is high for exactly one cycle, PIPE_LAT (20) cycles after the cycle in which `commit` was high.
- R7: A second commit made before the previous sync pulse has appeared still loads its word, and it produces its own sync pulse at its own delay.
- R8: While `rst_n` is low, `freq_word`, `commit` and `sync` are zero. Every staged byte is cleared, so a load with no new writes commits zero.
- R9: A staged byte that is not rewritten keeps its value across commits, so that a later load commits a partially updated word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select for byte writes, active low |
| wr_n | input | 1 | Write strobe, data captured on its rising edge |
| addr | input | 3 | Staged byte address (0 = least significant) |
| din | input | 8 | Byte data |
| load_n | input | 1 | Load strobe, falling edge commits the staged word |
| freq_word | output | 48 | Active phase increment for the accumulator |
| commit | output | 1 | One-cycle pulse when the staged word is taken |
| sync | output | 1 | One-cycle pulse when the new frequency reaches the output |

## Verification
The assertions check the following on every clock cycle:
- The active word moves only directly after a commit, and it then takes the staged value.
- Neither `commit` nor `sync` is ever high for two cycles in a row.
- Every sync pulse has an outstanding commit behind it.
- All outputs are zero while reset is held.

Only the bench scenarios can show the rest:
- The byte lanes, and the exact cycle counts from the load edge to the commit and to the sync.
- That chip-select-high writes and writes to the unused addresses are ignored.
- That overlapping loads each keep their own word and their own pulse.
- That reset empties the staging buffer.

// File: rtl/nco_freq_loader.sv
module nco_freq_loader #(
  parameter int DW       = 8,
  parameter int NBYTES   = 6,
  parameter int AW       = 3,
  parameter int PIPE_LAT = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   wr_n,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          din,
  input  logic                   load_n,
  output logic [DW*NBYTES-1:0]   freq_word,
  output logic                   commit,
  output logic                   sync
);
  localparam int FW = DW * NBYTES;
  localparam int PW = $clog2(PIPE_LAT + 1) + 1;

  logic [FW-1:0]       staged;
  logic [2:0]          ld_s;
  logic [PIPE_LAT-1:0] dly;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    always_ff @(posedge wr_n or negedge rst_n)
      if (!rst_n)
        staged[g*DW +: DW] <= '0;
      else if (!cs_n && addr == AW'(g))
        staged[g*DW +: DW] <= din;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ld_s <= '1;
    else        ld_s <= {ld_s[1:0], load_n};

  assign commit = ld_s[2] & ~ld_s[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      freq_word <= '0;
    else if (commit) freq_word <= staged;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dly <= '0;
    else        dly <= {dly[PIPE_LAT-2:0], commit};

  assign sync = dly[PIPE_LAT-1];

  logic [PW-1:0] pending;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pending <= '0;
    else if (commit && !sync) pending <= pending + 1'b1;
    else if (sync && !commit) pending <= pending - 1'b1;

  // R4
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable(freq_word));
  // R1
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(commit) |-> freq_word == $past(staged));
  // R5
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R6
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !sync);
  // R7
  sync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> pending != '0);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (freq_word == '0 && !sync && !commit));
endmodule

// File: tb/tb_nco_freq_loader.sv
module tb_nco_freq_loader;
  localparam int LAT = 20;
  logic clk = 0, rst_n = 0, cs_n = 1, wr_n = 1, load_n = 1;
  logic [2:0] addr = 0;
  logic [7:0] din = 0;
  logic [47:0] freq_word;
  logic commit, sync;

  nco_freq_loader #(.PIPE_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .din(din), .load_n(load_n), .freq_word(freq_word), .commit(commit),
    .sync(sync));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0, loads = 0, syncs_seen = 0;
  logic [47:0] model = '0;
  int exp_commit_q[$];
  logic [47:0] exp_word_q[$];
  int exp_sync_q[$];
  bit word_due = 0;
  logic [47:0] word_exp;

  task automatic check(bit ok, string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (word_due) begin
      check(freq_word == word_exp, "R1 committed word", freq_word, word_exp);
      word_due = 0;
    end
    if (commit) begin
      if (exp_commit_q.size() == 0) check(0, "R5 unexpected commit", 48'(cyc), 0);
      else begin
        int c;
        c = exp_commit_q.pop_front();
        check(c == cyc, "R5 commit cycle", 48'(cyc), 48'(c));
        word_exp = exp_word_q.pop_front();
        word_due = 1;
        exp_sync_q.push_back(cyc + LAT);
      end
    end
    if (sync) begin
      syncs_seen++;
      if (exp_sync_q.size() == 0) check(0, "R6 unexpected sync", 48'(cyc), 0);
      else begin
        int s;
        s = exp_sync_q.pop_front();
        check(s == cyc, "R6 sync cycle", 48'(cyc), 48'(s));
      end
    end
  end

  task automatic write_byte(logic [2:0] a, logic [7:0] d, bit sel);
    @(negedge clk);
    addr = a; din = d; cs_n = !sel;
    #1 wr_n = 0;
    #2 wr_n = 1;
    #1 cs_n = 1;
    if (sel && a < 6) model[a*8 +: 8] = d;
  endtask

  task automatic write_word(logic [47:0] w);
    for (int i = 0; i < 6; i++) write_byte(3'(i), w[i*8 +: 8], 1);
  endtask

  task automatic do_load();
    @(negedge clk);
    load_n = 0;
    loads++;
    exp_commit_q.push_back(cyc + 2);
    exp_word_q.push_back(model);
    repeat (3) @(negedge clk);
    load_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle();
    repeat (LAT + 6) @(negedge clk);
  endtask

  task automatic run();
    repeat (3) @(negedge clk);
    // R8 reset state
    check(freq_word == 0, "R8 reset freq_word", freq_word, 0);
    check({commit, sync} == 0, "R8 reset pulses", 48'({commit, sync}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 staging alone does not move the active word
    write_word(48'h0123_4567_89AB);
    repeat (4) @(negedge clk);
    check(freq_word == 0, "R4 staged not active", freq_word, 0);
    do_load(); idle();

    // R9 partial update
    write_byte(3'd2, 8'h5A, 1);
    write_byte(3'd5, 8'hC3, 1);
    do_load(); idle();

    // R2 chip select high ignored
    write_byte(3'd1, 8'hEE, 0);
    write_byte(3'd4, 8'h11, 0);
    do_load(); idle();

    // R3 addresses 6 and 7 ignored
    write_byte(3'd6, 8'hFF, 1);
    write_byte(3'd7, 8'h77, 1);
    do_load(); idle();

    // R7 overlapping loads
    write_word(48'hFEDC_BA98_7654);
    do_load();
    write_byte(3'd0, 8'h01, 1);
    do_load();
    write_byte(3'd3, 8'h99, 1);
    do_load();
    idle();
    check(exp_sync_q.size() == 0 && exp_commit_q.size() == 0,
          "R7 all pulses seen", 48'(exp_sync_q.size()), 0);
    check(syncs_seen == loads, "R7 sync count", 48'(syncs_seen), 48'(loads));

    // R8 asynchronous reset clears the buffer
    write_word(48'hA5A5_5A5A_1234);
    @(negedge clk);
    #3 rst_n = 0;
    #1;
    check(freq_word == 0, "R8 async clear", freq_word, 0);
    check({commit, sync} == 0, "R8 async pulses", 48'({commit, sync}), 0);
    @(negedge clk);
    rst_n = 1;
    model = '0;
    repeat (2) @(negedge clk);
    do_load(); idle();
    check(freq_word == 0, "R8 buffer cleared", freq_word, 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 48'(cyc), 0);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule